// File: doc/BRIEF.md
# Packed Ternary Logic Lane Unit

The unit evaluates three-valued logic (zero, one, unknown) on a whole word of independent lanes in one clock. Every operand word packs a number of lanes of two bits each. For each lane the unit forms the ternary conjunction of two operands, and each operand can first be complemented under its own control bit. A separate output carries the ternary complement of the first operand, taken without any polarity control. This is the inner step of a word-parallel three-valued simulator, which evaluates an inverter/AND netlist on many patterns at once.

Both results are captured in one output register stage when the input strobe is high, and the output strobe follows the input strobe one clock later. The register holds its contents while the strobe is low. The lane code `10` is outside the encoding, and its result is not defined.

Top module: `tern_lane_unit`

## Requirements
- R1: Each lane is two bits wide, and lane b sits at bits [2b+1:2b]. Zero is encoded `00`, one is `01` and unknown is `11`. A word made only of `01` lanes is the constant one, and a word made only of `11` lanes is all-unknown.
- R2: `not_o` lane b is the ternary complement of `op_a_i` lane b: `00`→`01`, `01`→`00`, `11`→`11`. `inv_a_i` has no effect on it.
- R3: An `and_o` lane is `00` whenever either effective operand lane is `00`, and the other operand does not matter, unknown included.
- R4: An `and_o` lane is `01` only when both effective operands are `01`. Every other legal combination gives `11`.
- R5: With `inv_a_i`=1, the effective first operand is the ternary complement of `op_a_i`.
- R6: With `inv_b_i`=1, the effective second operand is the ternary complement of `op_b_i`. This is independent of `inv_a_i`, so all four polarity combinations are available.
- R7: `and_o` and `not_o` are registered. A word presented with `valid_i`=1 appears on the outputs after the next rising clock edge, and `valid_o` equals `valid_i` one cycle late.
- R8: While `rst_ni` is low, `and_o`, `not_o` and `valid_o` are zero.
- R9: A lane's results depend only on the same lane of the inputs. Changing one input lane changes no other output lane.
- R10: A clock edge with `valid_i`=0 leaves `and_o` and `not_o` unchanged, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word strobe |
| op_a_i | input | 2*LANES | First operand, packed lanes |
| op_b_i | input | 2*LANES | Second operand, packed lanes |
| inv_a_i | input | 1 | Complement the first operand before the AND |
| inv_b_i | input | 1 | Complement the second operand before the AND |
| and_o | output | 2*LANES | Registered lane-wise ternary AND |
| not_o | output | 2*LANES | Registered lane-wise ternary NOT of op_a_i |
| valid_o | output | 1 | Output strobe, one cycle after valid_i |

## Verification
The bench applies all nine legal lane pairs under each of the four polarity settings, then random legal words. This exposes a bitwise AND, which turns one AND unknown into `01` instead of `11`, and a bitwise NOT, which turns unknown into `00`. A zero paired with unknown is checked to come out as zero, so a design that spreads the unknown would fail there. Single-lane perturbations would catch shifted lane slicing. Idle cycles with new data on the inputs would reveal a register that loads without the strobe. The strobe is also sampled on both sides of the capture edge, so an extra or missing register stage shows up as a latency error.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;
  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_ONE  = 2'b01;
  localparam trit_t T_UNK  = 2'b11;
endpackage

// File: rtl/tern_inv_word.sv
module tern_inv_word #(
  parameter int LANES = 16,
  localparam int W = 2 * LANES
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import tern_pkg::*;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    trit_t t;
    always_comb begin
      t = d_i[2*b +: 2];
      if (en_i) begin
        case (t)
          T_ZERO:  t = T_ONE;
          T_ONE:   t = T_ZERO;
          default: t = t; // unknown stays unknown
        endcase
      end
    end
    assign q_o[2*b +: 2] = t;
  end
endmodule

// File: rtl/tern_and_word.sv
module tern_and_word #(
  parameter int LANES = 16,
  localparam int W = 2 * LANES
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  import tern_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    trit_t a, b, y;
    assign a = a_i[2*l +: 2];
    assign b = b_i[2*l +: 2];
    always_comb begin
      if (a == T_ZERO || b == T_ZERO)     y = T_ZERO; // zero dominates
      else if (a == T_ONE && b == T_ONE)  y = T_ONE;
      else                                y = T_UNK;
    end
    assign y_o[2*l +: 2] = y;
  end
endmodule

// File: rtl/tern_lane_unit.sv
module tern_lane_unit #(
  parameter int LANES = 16,
  localparam int W = 2 * LANES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         inv_a_i,
  input  logic         inv_b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] not_o,
  output logic         valid_o
);
  logic [W-1:0] a_eff, b_eff, and_d, not_d;
  logic [W-1:0] and_q, not_q;
  logic         valid_q;

  tern_inv_word #(.LANES(LANES)) u_inv_a (.en_i(inv_a_i), .d_i(op_a_i), .q_o(a_eff));
  tern_inv_word #(.LANES(LANES)) u_inv_b (.en_i(inv_b_i), .d_i(op_b_i), .q_o(b_eff));
  tern_inv_word #(.LANES(LANES)) u_not   (.en_i(1'b1),    .d_i(op_a_i), .q_o(not_d));
  tern_and_word #(.LANES(LANES)) u_and   (.a_i(a_eff), .b_i(b_eff), .y_o(and_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      and_q   <= '0;
      not_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        and_q <= and_d;
        not_q <= not_d;
      end
    end
  end

  assign and_o   = and_q;
  assign not_o   = not_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/tern_lane_unit_chk.sv
module tern_lane_unit_chk #(
  parameter int LANES = 16,
  localparam int W = 2 * LANES
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] op_b_i,
  input logic         inv_a_i,
  input logic         inv_b_i,
  input logic [W-1:0] and_o,
  input logic [W-1:0] not_o,
  input logic         valid_o
);
  assert_valid_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(and_o) && $stable(not_o)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R8: assert (valid_o == 1'b0 && and_o == '0 && not_o == '0);
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assert_zero_dom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !inv_a_i && op_a_i[2*b +: 2] == 2'b00) |=> (and_o[2*b +: 2] == 2'b00));
    assert_one_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !inv_a_i && !inv_b_i && op_a_i[2*b +: 2] == 2'b01 && op_b_i[2*b +: 2] == 2'b01)
      |=> (and_o[2*b +: 2] == 2'b01));
    assert_not_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_a_i[2*b +: 2] == 2'b01) |=> (not_o[2*b +: 2] == 2'b00));
    assert_not_unk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_a_i[2*b +: 2] == 2'b11) |=> (not_o[2*b +: 2] == 2'b11));
  end
endmodule

bind tern_lane_unit tern_lane_unit_chk #(.LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
  .inv_a_i(inv_a_i), .inv_b_i(inv_b_i), .and_o(and_o), .not_o(not_o), .valid_o(valid_o)
);

// File: tb/tern_lane_unit_tb_top.sv
module tern_lane_unit_tb_top;
  localparam int LANES = 16;
  localparam int W = 2 * LANES;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, inv_a_i = 1'b0, inv_b_i = 1'b0;
  logic [W-1:0] op_a_i = '0, op_b_i = '0;
  logic [W-1:0] and_o, not_o;
  logic valid_o;
  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  tern_lane_unit #(.LANES(LANES)) dut_i (.*);

  function automatic logic [1:0] r_not(logic [1:0] t);
    case (t)
      2'b00:   return 2'b01;
      2'b01:   return 2'b00;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] r_and(logic [1:0] a, logic [1:0] b);
    if (a == 2'b00 || b == 2'b00) return 2'b00;
    if (a == 2'b01 && b == 2'b01) return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [1:0] code(int k);
    case (k % 3)
      0:       return 2'b00;
      1:       return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one strobe, outputs checked at the following negedge
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic ia, logic ib);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; inv_a_i = ia; inv_b_i = ib; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic check_word(string req, logic [W-1:0] a, logic [W-1:0] b, logic ia, logic ib);
    logic [W-1:0] ea, en;
    apply(a, b, ia, ib);
    for (int l = 0; l < LANES; l++) begin
      logic [1:0] xa, xb;
      xa = ia ? r_not(a[2*l +: 2]) : a[2*l +: 2];
      xb = ib ? r_not(b[2*l +: 2]) : b[2*l +: 2];
      ea[2*l +: 2] = r_and(xa, xb);
      en[2*l +: 2] = r_not(a[2*l +: 2]);
    end
    chk({req, " and"}, and_o, ea);
    chk({req, " not"}, not_o, en);
  endtask

  task automatic t_reset;
    #5;
    chk("R8 reset", {and_o, not_o, 31'b0, valid_o}, '0);
    @(negedge clk_i); @(negedge clk_i);
    chk("R8 reset held", {and_o, not_o, 31'b0, valid_o}, '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_constants;
    check_word("R1 one&unknown", {LANES{2'b01}}, {LANES{2'b11}}, 1'b0, 1'b0);
    chk("R1 const", and_o, {LANES{2'b11}});
    check_word("R1 unknown word", {LANES{2'b11}}, {LANES{2'b01}}, 1'b0, 1'b0);
    chk("R2 unk not", not_o, {LANES{2'b11}});
  endtask

  // all nine legal pairs under every polarity (R3 R4 R5 R6)
  task automatic t_table;
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        logic [W-1:0] a, b;
        for (int l = 0; l < LANES; l++) begin
          a[2*l +: 2] = code((l + 9 * s) % 9 / 3);
          b[2*l +: 2] = code((l + 9 * s) % 9);
        end
        case (p)
          0: check_word("R3_R4 plain", a, b, 1'b0, 1'b0);
          1: check_word("R5 inv_a", a, b, 1'b1, 1'b0);
          2: check_word("R6 inv_b", a, b, 1'b0, 1'b1);
          default: check_word("R5_R6 both", a, b, 1'b1, 1'b1);
        endcase
      end
    end
    // zero against unknown must stay zero
    check_word("R3 zero_vs_unk", {LANES{2'b00}}, {LANES{2'b11}}, 1'b0, 1'b0);
    chk("R3 zero result", and_o, '0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 64; i++) begin
      logic [W-1:0] a, b;
      for (int l = 0; l < LANES; l++) begin
        a[2*l +: 2] = code(int'($urandom % 3));
        b[2*l +: 2] = code(int'($urandom % 3));
      end
      check_word("R4 random", a, b, i[0], i[1]);
    end
  endtask

  task automatic t_isolation;
    logic [W-1:0] a;
    a = {LANES{2'b01}};
    a[2*5 +: 2] = 2'b00;
    apply(a, {LANES{2'b01}}, 1'b0, 1'b0);
    chk("R9 single lane", and_o, a);
    a[2*5 +: 2] = 2'b11;
    apply(a, {LANES{2'b01}}, 1'b0, 1'b0);
    chk("R9 single lane unk", and_o, a);
  endtask

  task automatic t_hold;
    logic [W-1:0] ha, hn;
    apply({LANES{2'b01}}, {LANES{2'b01}}, 1'b0, 1'b0);
    ha = and_o; hn = not_o;
    op_a_i = '0; op_b_i = {LANES{2'b11}}; inv_a_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R10 hold and", and_o, ha);
    chk("R10 hold not", not_o, hn);
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    valid_i = 1'b1;
    #1 chk("R7 before edge", {31'b0, valid_o}, '0);
    @(posedge clk_i); #1;
    chk("R7 after edge", {31'b0, valid_o}, 1);
    @(negedge clk_i);
    valid_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R7 drop", {31'b0, valid_o}, '0);
  endtask

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_constants();
    t_table();
    t_random();
    t_isolation();
    t_hold();
    t_latency();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule